// File: doc/BRIEF.md
# Bit-Serial Lookup-Table FIR Filter

This block is a finite impulse response filter that uses no hardware multiplier. The taps are split into groups of four. Each group has a sixteen-entry table that holds every possible sum of that group's coefficients. The tables are computed at elaboration from a packed coefficient parameter.

When a new sample is accepted, the delay line shifts by one. The block then walks through the sixteen bit positions of the stored samples, one bit per cycle, starting with the sign bit. In each cycle, bit b of each of the four samples in a group forms that group's table address. The table outputs are summed, and a left-shifting accumulator folds the sum in. The sign-bit contribution is negated, because in two's complement it carries negative weight. After the last bit cycle, the exact dot product is arithmetically shifted right, saturated to a 16-bit signed result and presented with a one-cycle valid pulse.

The block is used as a simple sample-in, result-out engine. The user offers a sample when `ready` is high and then waits for `resultValid`. Any sample offered while the block is busy is dropped.

Top module: `dafir_top`

## Requirements
- R1: After reset, `ready` is 1, `resultValid` is 0, `result` is 0, and every delay-line tap holds zero.
- R2: A sample is accepted on a rising edge where `sampleValid` and `ready` are both 1. `ready` is then 0 for exactly 16 cycles.
- R3: If `sampleValid` is high while `ready` is 0, the delay line does not change and no extra result is produced.
- R4: `resultValid` is 1 for exactly one cycle, 16 clock edges after the accepting edge, and `ready` is 1 in that same cycle.
- R5: The result is computed as follows. Take sum over k of c[k]·x[n-k], where tap 0 is the newest sample and coefficient k occupies bits k·COEF_W and up of `COEFS`. Shift that sum arithmetically right by OUT_SHIFT (default 8), which rounds toward minus infinity. Then saturate.
- R6: Negative samples, including −32768, are weighted correctly. The sign bit of each sample counts −2^15.
- R7: Results above 32767 saturate to 32767 (0x7FFF). Results below −32768 saturate to −32768 (0x8000).
- R8: `result` holds its value in every cycle where `resultValid` is 0.
- R9: A new sample may be accepted in the same cycle that `resultValid` is high. The next result then follows 16 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | A new sample is offered on `sampleIn` |
| sampleIn | input | DATA_W | Two's complement input sample |
| ready | output | 1 | Block is idle and will accept a sample |
| resultValid | output | 1 | One-cycle pulse marking a new `result` |
| result | output | OUT_W | Saturated, scaled filter output |

## Verification
The assertions assume the following about the inputs:
- `sampleValid` may be asserted in any cycle, whether or not the block is busy.
- `rstN` is held low for at least one clock edge before the first sample.

The stimulus changes inputs only on falling clock edges. Samples are offered both while idle and deliberately while busy, so the drop rule is exercised. The bench also offers a sample in the very cycle a result appears, which tests the back-to-back case. Sample values are kept within 16-bit two's complement and include both extremes. This reaches saturation in both directions and the pure sign-bit pattern.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

  // Control strobes from sequencer to datapath
  typedef struct packed {
    logic load;    // shift delay line with new sample
    logic first;   // sign-bit cycle: start accumulator with negated sum
    logic step;    // any bit cycle: update accumulator
    logic finish;  // last bit cycle: capture scaled result
  } dafirStrobe_t;

endpackage

// File: rtl/dafir_ctrl.sv
module dafir_ctrl
  import dafir_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sampleValid,
  output logic                      ready,
  output dafirStrobe_t              strb,
  output logic [$clog2(DATA_W)-1:0] bitIdx
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] TOP_BIT = CNT_W'(DATA_W - 1);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t state;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sampleValid) begin
            state  <= ST_RUN;
            bitCnt <= TOP_BIT;
          end
        end
        default: begin
          if (bitCnt == '0) state <= ST_IDLE;
          else              bitCnt <= bitCnt - 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    strb.load   = (state == ST_IDLE) && sampleValid;
    strb.step   = (state == ST_RUN);
    strb.first  = (state == ST_RUN) && (bitCnt == TOP_BIT);
    strb.finish = (state == ST_RUN) && (bitCnt == '0);
  end

  assign ready  = (state == ST_IDLE);
  assign bitIdx = bitCnt;

endmodule

// File: rtl/dafir_datapath.sv
module dafir_datapath
  import dafir_pkg::*;
#(
  parameter int NUM_TAPS  = 8,
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int OUT_W     = 16,
  parameter int OUT_SHIFT = 8,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dafirStrobe_t              strb,
  input  logic [$clog2(DATA_W)-1:0] bitIdx,
  input  logic [DATA_W-1:0]         sampleIn,
  output logic                      resultValid,
  output logic [OUT_W-1:0]          result
);

  localparam int GRP_SIZE   = 4;
  localparam int TBL_DEPTH  = 1 << GRP_SIZE;
  localparam int NUM_GROUPS = NUM_TAPS / GRP_SIZE;
  localparam int ENT_W      = COEF_W + 2;
  localparam int SUM_W      = COEF_W + $clog2(NUM_TAPS) + 1;
  localparam int ACC_W      = SUM_W + DATA_W;

  localparam logic signed [ACC_W-1:0] OUT_MAX =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] OUT_MIN = ~OUT_MAX;

  // Sum of the coefficients in group grp selected by the bits of addr
  function automatic logic signed [ENT_W-1:0] subsetSum(int grp, int addr);
    logic signed [ENT_W-1:0]  s;
    logic signed [COEF_W-1:0] c;
    s = '0;
    for (int j = 0; j < GRP_SIZE; j++) begin
      c = COEFS[(grp*GRP_SIZE+j)*COEF_W +: COEF_W];
      if (((addr >> j) & 1) != 0) s = s + ENT_W'(c);
    end
    return s;
  endfunction

  logic [DATA_W-1:0] taps [NUM_TAPS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_TAPS; k++) taps[k] <= '0;
    end else if (strb.load) begin
      taps[0] <= sampleIn;
      for (int k = 1; k < NUM_TAPS; k++) taps[k] <= taps[k-1];
    end
  end

  logic signed [ENT_W-1:0] tblOut [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    logic signed [ENT_W-1:0] tbl [TBL_DEPTH];
    logic [GRP_SIZE-1:0] addr;
    for (genvar e = 0; e < TBL_DEPTH; e++) begin : g_entry
      assign tbl[e] = subsetSum(g, e);
    end
    for (genvar j = 0; j < GRP_SIZE; j++) begin : g_addr
      assign addr[j] = taps[g*GRP_SIZE+j][bitIdx];
    end
    assign tblOut[g] = tbl[addr];
  end

  logic signed [SUM_W-1:0] bitSum;
  always_comb begin
    bitSum = '0;
    for (int g = 0; g < NUM_GROUPS; g++) bitSum = bitSum + SUM_W'(tblOut[g]);
  end

  logic signed [ACC_W-1:0] acc, accNext, scaled;
  logic [OUT_W-1:0] satVal;

  always_comb begin
    if (strb.first) accNext = -ACC_W'(bitSum);
    else            accNext = (acc <<< 1) + ACC_W'(bitSum);
    scaled = accNext >>> OUT_SHIFT;
    if (scaled > OUT_MAX)      satVal = {1'b0, {(OUT_W-1){1'b1}}};
    else if (scaled < OUT_MIN) satVal = {1'b1, {(OUT_W-1){1'b0}}};
    else                       satVal = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc         <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      if (strb.step)   acc    <= accNext;
      if (strb.finish) result <= satVal;
      resultValid <= strb.finish;
    end
  end

endmodule

// File: rtl/dafir_top.sv
module dafir_top
  import dafir_pkg::*;
#(
  parameter int NUM_TAPS  = 8,
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int OUT_W     = 16,
  parameter int OUT_SHIFT = 8,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = {
    16'sd120, -16'sd250, 16'sd700, 16'sd1500,
    16'sd1500, 16'sd700, -16'sd250, 16'sd120}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              ready,
  output logic              resultValid,
  output logic [OUT_W-1:0]  result
);

  dafirStrobe_t strb;
  logic [$clog2(DATA_W)-1:0] bitIdx;

  dafir_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .ready(ready), .strb(strb), .bitIdx(bitIdx)
  );

  dafir_datapath #(
    .NUM_TAPS(NUM_TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W),
    .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT), .COEFS(COEFS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIdx(bitIdx),
    .sampleIn(sampleIn), .resultValid(resultValid), .result(result)
  );

endmodule

// File: rtl/dafir_checker.sv
module dafir_checker #(
  parameter int DATA_W = 16,
  parameter int OUT_W  = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleValid,
  input logic             ready,
  input logic             resultValid,
  input logic [OUT_W-1:0] result
);

  logic [7:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     busyCnt <= '0;
    else if (sampleValid && ready) busyCnt <= '0;
    else if (!ready)               busyCnt <= busyCnt + 1'b1;
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && ready) |=> !ready);                                 // R2

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (busyCnt == 8'(DATA_W)));                           // R4

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);                                      // R4

  AST_READY_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> ready);                                             // R9

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !sampleValid) |=> !resultValid);                          // R3

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(result));                                  // R8

endmodule

bind dafir_top dafir_checker #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/test_dafir_top.sv
module test_dafir_top;

  localparam int NT = 8;
  localparam int SH = 8;
  localparam int LAT = 17;   // falling edges from drive to visible result
  localparam logic signed [15:0] CF [NT] = '{
    16'sd120, -16'sd250, 16'sd700, 16'sd1500,
    16'sd1500, 16'sd700, -16'sd250, 16'sd120};

  logic clk = 0, rstN = 0, sampleValid = 0;
  logic [15:0] sampleIn = '0;
  logic ready, resultValid;
  logic [15:0] result;

  int nChecks = 0, nFails = 0;
  longint hist [NT];

  always #2.5 clk = ~clk;

  dafir_top i_dafir_top (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .ready(ready), .resultValid(resultValid), .result(result)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint modelOut();
    longint s = 0;
    for (int k = 0; k < NT; k++) s += longint'(CF[k]) * hist[k];
    s = s >>> SH;
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  // Offer one sample; optionally intrude with a sample while busy.
  task automatic pushSample(input logic signed [15:0] x, input bit intrude, input string req);
    int lat;
    longint got, exp;
    while (!ready) @(negedge clk);
    sampleValid = 1; sampleIn = x;
    for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'(x);
    @(negedge clk);
    sampleValid = 0;
    check(ready == 0, "R2 busy after accept", ready, 0);
    lat = 1;
    while (!resultValid && lat < 40) begin
      @(negedge clk); lat++;
      if (intrude && lat == 3) begin sampleValid = 1; sampleIn = 16'h7abc; end
      if (intrude && lat == 4) begin sampleValid = 0; end
    end
    check(lat == LAT, "R4 latency", lat, LAT);
    check(ready == 1, "R4 ready with result", ready, 1);
    got = longint'($signed(result));
    exp = modelOut();
    check(got == exp, req, got, exp);
  endtask

  task automatic testReset();
    check(ready == 1, "R1 ready", ready, 1);
    check(resultValid == 0, "R1 resultValid", resultValid, 0);
    check(result == 0, "R1 result", result, 0);
  endtask

  task automatic testImpulse();
    // first push after reset: older taps must be zero (R1)
    pushSample(16'sd256, 0, "R1 R5 impulse head");
    for (int i = 1; i < NT; i++) pushSample(16'sd0, 0, "R5 impulse tail");
    pushSample(-16'sd256, 0, "R6 negative impulse");
    for (int i = 1; i < 4; i++) pushSample(16'sd0, 0, "R6 negative tail");
  endtask

  task automatic testMixed();
    pushSample(16'sd1234, 0, "R5 mixed");
    pushSample(-16'sd7, 0, "R5 mixed");
    pushSample(16'sd300, 0, "R6 mixed sign");
    pushSample(-16'sd32768, 0, "R6 most negative");
    pushSample(16'sd5, 0, "R5 mixed");
  endtask

  task automatic testSaturation();
    for (int i = 0; i < NT; i++) pushSample(16'sd32767, 0, "R7 positive saturation");
    for (int i = 0; i < NT; i++) pushSample(-16'sd32768, 0, "R7 negative saturation");
  endtask

  task automatic testIgnoreBusy();
    pushSample(16'sd400, 1, "R3 intruder ignored");
    pushSample(16'sd0, 0, "R3 line unchanged");
    pushSample(16'sd0, 0, "R3 line unchanged");
  endtask

  task automatic testHold();
    logic [15:0] held;
    held = result;
    repeat (5) @(negedge clk);
    check(result == held, "R8 result held", result, held);
    check(resultValid == 0, "R8 no pulse while idle", resultValid, 0);
  endtask

  task automatic testBackToBack();
    // pushSample returns in the result cycle; next push is driven at once
    pushSample(16'sd2000, 0, "R9 back-to-back");
    pushSample(-16'sd1500, 0, "R9 back-to-back");
    pushSample(16'sd999, 0, "R9 back-to-back");
  endtask

  initial begin
    for (int k = 0; k < NT; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testImpulse();
    testMixed();
    testHold();
    testIgnoreBusy();
    testSaturation();
    testBackToBack();
    testHold();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule